// File: doc/BRIEF.md
# Buffered First-Word-Fall-Through FIFO

This is a single-clock queue. Its read data comes straight from a flip-flop rather than from a memory output. Inside are a small storage array with a registered read and one output register that serves as that read register. The control logic keeps the output register full whenever the array holds data. As a result, the oldest entry is already on `dout` whenever `readable` is high, and a consumer takes it by raising `re` for one cycle.

The producer drives `din` with `we` whenever `writable` is high. A write into an empty queue shows up on the read side exactly two cycles later. Once data is flowing, back-to-back reads see a new entry every cycle with no gaps. The `level` output counts every entry held, including the one in the output register. The configured depth is the total capacity and can be any integer of two or more. The storage array holds one entry fewer than that depth, and its pointers wrap at the slot count, so the slot count need not be a power of two.

Top module: `bufFwftFifo`

## Requirements
- R1: In the first cycle after reset is released, `level` is 0, `readable` is low and `writable` is high.
- R2: Each clock edge adds one to `level` for an accepted write (`we` and `writable`) and subtracts one for an accepted read (`re` and `readable`). When both are accepted in the same cycle, `level` is unchanged.
- R3: `readable` is low whenever `level` is 0 and high whenever `level` is 2 or more. `writable` is high exactly when `level` is below DEPTH.
- R4: When the queue is empty, data written in cycle c is not readable in cycle c+1. It is readable with that data on `dout` in cycle c+2.
- R5: Entries leave in the order they were written. When a read is accepted while other entries remain, `readable` stays high in the next cycle, so consecutive reads run without a gap.
- R6: While `readable` is high and `re` is low, `dout` keeps its value into the next cycle.
- R7: A write while `level` equals DEPTH is dropped, even if a read is accepted in the same cycle. The dropped data never appears on `dout`, and `level` does not exceed DEPTH.
- R8: A read while `readable` is low is dropped. `level` stays at 0, and a later write is still the next entry read out.
- R9: Total capacity is exactly DEPTH entries. This holds when the internal slot count (DEPTH-1) is not a power of two, and order is kept as the pointers wrap many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Write request |
| din | input | WIDTH | Write data |
| writable | output | 1 | Space available; a write is accepted when this and `we` are high |
| re | input | 1 | Read request; takes the entry shown on `dout` |
| dout | output | WIDTH | Oldest entry, valid while `readable` is high |
| readable | output | 1 | Output register holds an entry |
| level | output | clog2(DEPTH+1) | Number of entries held, including the output register |

## Verification
The bench runs a depth of four, which gives three internal slots, so the pointer wrap is checked at a count that is not a power of two. Each wrap point is crossed many times under fill-and-drain and steady streaming. A wrong wrap would reorder or lose entries. If the array holds too many slots, the capacity check sees a wrong `level` or `writable`.

The first-word path is checked one cycle early as well as on time. A design that bypassed the array would turn readable too soon, and one with an extra stage would be late. Continuous draining checks that no gap appears, which catches a design that refills the output register only when it is empty. Writes into a full queue, including those paired with a read, check that a freed slot is not refilled by a write that was refused. Reads on an empty queue check that no false entry is left behind.

// File: rtl/bufFifoPkg.sv
package bufFifoPkg;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic memWrite;  // store din at the write pointer
    logic memRead;   // move the entry at the read pointer into the output register
  } fifoStrobes_t;

endpackage

// File: rtl/fifoWrapPtr.sv
module fifoWrapPtr #(
  parameter int SLOTS = 3,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] LAST = W'(SLOTS - 1);

  // The wrap is an explicit compare, so SLOTS may be any integer.
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (adv) begin
      value <= (value == LAST) ? '0 : value + 1'b1;
    end
  end

endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import bufFifoPkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  output fifoStrobes_t     strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             writable,
  output logic             readable,
  output logic [LVL_W-1:0] level
);

  localparam int SLOTS = DEPTH - 1;

  logic [LVL_W-1:0] innerCount;
  logic             outValid;
  logic             wrOk;
  logic             rdOk;
  logic             innerHas;
  logic             outDrop;

  always_comb begin
    writable        = (level != LVL_W'(DEPTH));
    readable        = outValid;
    wrOk            = we && writable;
    rdOk            = re && outValid;
    innerHas        = (innerCount != '0);
    // Refill when the output register is empty or is being read this cycle.
    strobes.memRead  = innerHas && (!outValid || rdOk);
    strobes.memWrite = wrOk;
    outDrop          = rdOk && !strobes.memRead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      innerCount <= '0;
      outValid   <= 1'b0;
      level      <= '0;
    end else begin
      innerCount <= innerCount + LVL_W'(strobes.memWrite) - LVL_W'(strobes.memRead);
      level      <= level + LVL_W'(wrOk) - LVL_W'(rdOk);
      if (strobes.memRead) begin
        outValid <= 1'b1;
      end else if (outDrop) begin
        outValid <= 1'b0;
      end
    end
  end

  fifoWrapPtr #(.SLOTS(SLOTS), .W(PTR_W)) u_wrPtr (
    .clk  (clk),
    .rst  (rst),
    .adv  (strobes.memWrite),
    .value(wrPtr)
  );

  fifoWrapPtr #(.SLOTS(SLOTS), .W(PTR_W)) u_rdPtr (
    .clk  (clk),
    .rst  (rst),
    .adv  (strobes.memRead),
    .value(rdPtr)
  );

endmodule

// File: rtl/fifoData.sv
module fifoData
  import bufFifoPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLOTS = 3,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobes_t     strobes,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (strobes.memWrite) begin
      mem[wrPtr] <= din;
    end
  end

  // The registered read port doubles as the output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (strobes.memRead) begin
      dout <= mem[rdPtr];
    end
  end

endmodule

// File: rtl/bufFwftFifo.sv
module bufFwftFifo
  import bufFifoPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,   // total capacity, two or more
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int SLOTS = DEPTH - 1,
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] din,
  output logic             writable,
  input  logic             re,
  output logic [WIDTH-1:0] dout,
  output logic             readable,
  output logic [LVL_W-1:0] level
);

  fifoStrobes_t     strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  fifoCtrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .re      (re),
    .strobes (strobes),
    .wrPtr   (wrPtr),
    .rdPtr   (rdPtr),
    .writable(writable),
    .readable(readable),
    .level   (level)
  );

  fifoData #(.WIDTH(WIDTH), .SLOTS(SLOTS), .PTR_W(PTR_W)) u_data (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .wrPtr  (wrPtr),
    .rdPtr  (rdPtr),
    .din    (din),
    .dout   (dout)
  );

endmodule

// File: rtl/bufFwftFifoChk.sv
module bufFwftFifoChk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             we,
  input logic [WIDTH-1:0] din,
  input logic             writable,
  input logic             re,
  input logic [WIDTH-1:0] dout,
  input logic             readable,
  input logic [LVL_W-1:0] level
);

  logic [1:0]     upCnt;
  logic           accW;
  logic           accR;
  logic [LVL_W:0] expNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      upCnt <= '0;
    end else if (upCnt != 2'd3) begin
      upCnt <= upCnt + 1'b1;
    end
  end

  always_comb begin
    accW    = we && writable;
    accR    = re && readable;
    expNext = {1'b0, level} + (LVL_W + 1)'(accW) - (LVL_W + 1)'(accR);
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    (upCnt == 2'd0) |-> (level == '0 && !readable && writable));

  a_r2_level_step: assert property (@(posedge clk) disable iff (rst)
    (upCnt != 2'd0) |-> ({1'b0, level} == $past(expNext)));

  a_r3_empty_not_readable: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !readable);

  a_r3_many_readable: assert property (@(posedge clk) disable iff (rst)
    (level > LVL_W'(1)) |-> readable);

  a_r3_writable_space: assert property (@(posedge clk) disable iff (rst)
    writable == (level < LVL_W'(DEPTH)));

  a_r4_fill_latency: assert property (@(posedge clk) disable iff (rst)
    (upCnt >= 2'd2 && level == LVL_W'(1) && !$past(readable))
      |-> (readable == $past(accW, 2)));

  a_r5_no_bubble: assert property (@(posedge clk) disable iff (rst)
    (level > LVL_W'(1) && accR) |=> readable);

  a_r6_hold_dout: assert property (@(posedge clk) disable iff (rst)
    (upCnt != 2'd0 && $past(readable) && !$past(re)) |-> $stable(dout));

  a_r7_bounded_level: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

endmodule

bind bufFwftFifo bufFwftFifoChk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .we      (we),
  .din     (din),
  .writable(writable),
  .re      (re),
  .dout    (dout),
  .readable(readable),
  .level   (level)
);

// File: tb/test_bufFwftFifo.sv
`timescale 1ns/1ps
module test_bufFwftFifo;

  localparam int WIDTH = 8;
  localparam int DEPTH = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             we  = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic             re  = 1'b0;
  logic             writable;
  logic             readable;
  logic [WIDTH-1:0] dout;
  logic [LVL_W-1:0] level;

  int checks = 0;
  int fails  = 0;
  logic [WIDTH-1:0] model[$];

  always #5 clk = ~clk;

  bufFwftFifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_bufFwftFifo (
    .clk(clk), .rst(rst), .we(we), .din(din), .writable(writable),
    .re(re), .dout(dout), .readable(readable), .level(level)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // One cycle of stimulus against the reference queue.
  task automatic step(input logic w, input logic [WIDTH-1:0] d, input logic r);
    logic accW;
    logic accR;
    we = w; din = d; re = r;
    accW = w && writable;
    accR = r && readable;
    if (accR) begin
      chk("R5", int'(dout), int'(model[0]), "read order");
      void'(model.pop_front());
    end
    if (accW) model.push_back(d);
    tick();
    we = 1'b0; re = 1'b0;
    chk("R2", int'(level), model.size(), "level");
    chk("R3", int'(writable), int'(model.size() < DEPTH), "writable");
    if (model.size() == 0) chk("R3", int'(readable), 0, "readable when empty");
    if (model.size() > 1)  chk("R3", int'(readable), 1, "readable when several");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1", int'(level), 0, "level after reset");
    chk("R1", int'(readable), 0, "readable after reset");
    chk("R1", int'(writable), 1, "writable after reset");
  endtask

  task automatic t_first_word();
    step(1'b1, 8'hA5, 1'b0);
    chk("R4", int'(readable), 0, "readable one cycle after write");
    step(1'b0, '0, 1'b0);
    chk("R4", int'(readable), 1, "readable two cycles after write");
    chk("R4", int'(dout), 8'hA5, "first word data");
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 1'b0);
      chk("R6", int'(dout), 8'hA5, "dout held without read");
    end
    step(1'b0, '0, 1'b1);
  endtask

  task automatic t_full_and_drain(input logic [WIDTH-1:0] base);
    for (int i = 0; i < DEPTH; i++) step(1'b1, base + WIDTH'(i), 1'b0);
    chk("R9", int'(level), DEPTH, "capacity");
    chk("R7", int'(writable), 0, "writable at full");
    step(1'b1, 8'hEE, 1'b0);
    chk("R7", int'(level), DEPTH, "level after write at full");
    step(1'b1, 8'hEF, 1'b1);
    chk("R7", int'(level), DEPTH - 1, "write with read at full");
    while (model.size() > 0) begin
      chk("R5", int'(readable), 1, "no bubble while draining");
      step(1'b0, '0, 1'b1);
    end
  endtask

  task automatic t_underflow();
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R8", int'(level), 0, "read on empty");
      chk("R8", int'(readable), 0, "readable after empty read");
    end
    step(1'b1, 8'h77, 1'b1);
    step(1'b0, '0, 1'b0);
    chk("R8", int'(dout), 8'h77, "next entry after empty reads");
    step(1'b0, '0, 1'b1);
  endtask

  task automatic t_stream();
    step(1'b1, 8'h40, 1'b0);
    step(1'b1, 8'h41, 1'b0);
    step(1'b0, '0, 1'b0);
    for (int i = 0; i < 14; i++) begin
      step(1'b1, 8'h50 + WIDTH'(i), 1'b1);
      chk("R2", int'(level), 2, "steady level while streaming");
    end
    while (model.size() > 0) step(1'b0, '0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_first_word();
    t_full_and_drain(8'h10);
    t_underflow();
    t_stream();
    for (int r = 0; r < 3; r++) t_full_and_drain(8'h80 + WIDTH'(16 * r));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule